// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog of a small microcontroller. It counts ticks from one of two sources, picked by a static configuration pin: a tick from a dedicated slow oscillator, or an instruction clock derived inside the block by dividing the system clock by four. The count passes through an 8-stage base divider and then a 7-stage prescaler. A 3-bit select field in an 8-bit control register picks the prescaler tap. The remaining control bits are plain storage for software flags.

Software keeps the watchdog quiet with clear strobes. A configuration pin picks one of two clear modes. In the first, a single command is enough. In the second, two distinct commands must both arrive, in either order, before the count restarts. Entering halt and the external reset also restart the count. When the count expires, the block sends out a one-cycle reset request. The request is a full chip reset when the core is running and a warm reset when it is halted. A sticky time-out flag records that the request happened. A configuration pin can disable the whole function.

Top module: `wdog_paired_clear`

## Requirements
- R1: While and after `rst_n` is low, `rst_full`, `rst_warm` and `timeout_flag` are 0 and `ctl_rdata` reads 8'h00.
- R2: With the oscillator source and select field `ctl[2:0]` = 000, the reset request appears 256 counted ticks after the last restart. It is registered, so it is visible in the cycle after the clock edge that sampled the 256th tick.
- R3: A select value k (0 to 7) stretches the period to 256·2^k ticks.
- R4: Control bits [7:3] store and read back any written value and have no effect on the period.
- R5: With `cfg_enable` = 0 the block does not count, ignores every clear, and raises no reset request and no time-out flag.
- R6: With `cfg_dual_clear` = 0, a `clr_single` strobe restarts the count and `clr_one`/`clr_two` are ignored. A clear in the same cycle as the expiring tick wins, so no request is made.
- R7: With `cfg_dual_clear` = 1, the count restarts only once both `clr_one` and `clr_two` have been seen, in either order or in the same cycle, and `clr_single` is ignored. A partial record is dropped whenever the count restarts by any other path.
- R8: A `halt_enter` strobe restarts the count.
- R9: Expiry while `halted` = 1 pulses `rst_warm` instead of `rst_full`.
- R10: `timeout_flag` is set together with any reset request. It is cleared by an accepted software clear or by `halt_enter`.
- R11: With the instruction-clock source, one tick is counted per four system clocks. No ticks are counted while `halted` = 1.
- R12: Each reset request lasts exactly one cycle. The count restarts from zero in that same cycle, so the next request follows one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| cfg_enable | input | 1 | Static: watchdog function enabled |
| cfg_src_osc | input | 1 | Static: 1 selects the oscillator tick, 0 selects the instruction clock |
| cfg_dual_clear | input | 1 | Static: 1 requires the paired clear commands |
| osc_tick | input | 1 | One-cycle tick from the dedicated oscillator, already synchronous |
| halted | input | 1 | Core is in halt |
| halt_enter | input | 1 | One-cycle strobe when the halt command executes |
| clr_single | input | 1 | Single clear command strobe |
| clr_one | input | 1 | First paired clear command strobe |
| clr_two | input | 1 | Second paired clear command strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| rst_full | output | 1 | One-cycle full chip reset request |
| rst_warm | output | 1 | One-cycle warm reset request |
| timeout_flag | output | 1 | Sticky time-out flag |

## Verification
Each reset request is due one cycle after the edge that samples the expiring tick. The bench's driver knows exactly which edge samples which tick, so it queues the expected request kind together with that edge number. The monitor samples on the falling clock edge and pops the queue entry when a pulse appears. A pulse with no queued entry counts as a failure, which also covers single-cycle width, ignored clears and disabled operation. Instruction-clock requests are due near 1024 cycles after counting begins, and are matched within a small window because the divider phase is internal.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      WD_REQ_NONE = 2'd0,
      WD_REQ_FULL = 2'd1,
      WD_REQ_WARM = 2'd2
   } wd_req_e;
endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
   parameter int unsigned INSTR_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic src_osc,
   input  logic halted,
   input  logic osc_tick,
   output logic src_tick
);
   logic inst_tick;

   generate
      if (INSTR_DIV < 1) begin : g_bad_div
         $error("INSTR_DIV must be at least 1");
      end
      if (INSTR_DIV == 1) begin : g_no_div
         assign inst_tick = !halted;
      end else begin : g_div
         localparam int unsigned DW = $clog2(INSTR_DIV);
         localparam logic [DW-1:0] LAST = DW'(INSTR_DIV - 1);
         logic [DW-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (!halted)
               phase_q <= (phase_q == LAST) ? '0 : phase_q + DW'(1);
         end
         assign inst_tick = !halted && (phase_q == LAST);
      end
   endgenerate

   assign src_tick = enable && (src_osc ? osc_tick : inst_tick);

   assert_instr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_osc && halted) |-> !src_tick);
endmodule

// File: rtl/wdog_clr_qual.sv
module wdog_clr_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic dual,
   input  logic clr_single,
   input  logic clr_one,
   input  logic clr_two,
   input  logic flush,
   output logic clr_accept
);
   logic seen_one_q, seen_two_q;
   logic have_one, have_two;

   assign have_one   = seen_one_q || clr_one;
   assign have_two   = seen_two_q || clr_two;
   assign clr_accept = enable && (dual ? (have_one && have_two) : clr_single);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_one_q <= 1'b0;
         seen_two_q <= 1'b0;
      end else if (!enable || !dual || clr_accept || flush) begin
         seen_one_q <= 1'b0;
         seen_two_q <= 1'b0;
      end else begin
         seen_one_q <= have_one;
         seen_two_q <= have_two;
      end
   end

   assert_pair_ignores_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dual && !clr_one && !clr_two && !seen_one_q && !seen_two_q) |-> !clr_accept);
   assert_single_ignores_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual && !clr_single) |-> !clr_accept);
endmodule

// File: rtl/wdog_count_chain.sv
module wdog_count_chain
   import wdog_pkg::*;
#(
   parameter int unsigned BASE_BITS  = 8,
   parameter int unsigned PRE_STAGES = 7,
   parameter int unsigned SEL_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             clear,
   input  logic             halted,
   input  logic [SEL_W-1:0] sel,
   output logic             ovf_now,
   output wd_req_e          req_q
);
   localparam int unsigned CNT_W = BASE_BITS + PRE_STAGES;
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tap_mask;
   int unsigned      sel_eff;

   always_comb begin
      sel_eff  = (int'(sel) > int'(PRE_STAGES)) ? PRE_STAGES : int'(sel);
      tap_mask = ALL_ONES >> (PRE_STAGES - sel_eff);
   end

   assign ovf_now = enable && tick && !clear && ((cnt_q & tap_mask) == tap_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req_q <= WD_REQ_NONE;
      end else begin
         req_q <= WD_REQ_NONE;
         if (!enable || clear) begin
            cnt_q <= '0;
         end else if (ovf_now) begin
            cnt_q <= '0;
            req_q <= halted ? WD_REQ_WARM : WD_REQ_FULL;
         end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (req_q == WD_REQ_NONE && cnt_q == '0));
   assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q != WD_REQ_NONE) |=> (req_q == WD_REQ_NONE));
   assert_restart_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q != WD_REQ_NONE) |-> (cnt_q == '0));
   assert_quiet_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cnt_q == '0 && req_q == WD_REQ_NONE));
endmodule

// File: rtl/wdog_paired_clear.sv
module wdog_paired_clear
   import wdog_pkg::*;
#(
   parameter int unsigned BASE_BITS  = 8,
   parameter int unsigned PRE_STAGES = 7,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned CTL_W      = 8,
   parameter int unsigned INSTR_DIV  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic             cfg_src_osc,
   input  logic             cfg_dual_clear,
   input  logic             osc_tick,
   input  logic             halted,
   input  logic             halt_enter,
   input  logic             clr_single,
   input  logic             clr_one,
   input  logic             clr_two,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic             rst_full,
   output logic             rst_warm,
   output logic             timeout_flag
);
   generate
      if (CTL_W <= SEL_W) begin : g_bad_ctl
         $error("CTL_W must leave room for flag bits above the select field");
      end
      if (PRE_STAGES >= (1 << SEL_W)) begin : g_bad_sel
         $error("SEL_W too narrow to reach every prescaler stage");
      end
      if (BASE_BITS < 1) begin : g_bad_base
         $error("BASE_BITS must be at least 1");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_q;
   logic             src_tick;
   logic             clr_accept;
   logic             halt_clr;
   logic             ovf_now;
   wd_req_e          req;
   logic             to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (ctl_we)
         ctl_q <= ctl_wdata;
   end
   assign ctl_rdata = ctl_q;

   assign halt_clr = cfg_enable && halt_enter;

   wdog_tick_src #(.INSTR_DIV(INSTR_DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (cfg_enable),
      .src_osc  (cfg_src_osc),
      .halted   (halted),
      .osc_tick (osc_tick),
      .src_tick (src_tick)
   );

   wdog_clr_qual u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_enable),
      .dual       (cfg_dual_clear),
      .clr_single (clr_single),
      .clr_one    (clr_one),
      .clr_two    (clr_two),
      .flush      (halt_clr || ovf_now),
      .clr_accept (clr_accept)
   );

   wdog_count_chain #(
      .BASE_BITS  (BASE_BITS),
      .PRE_STAGES (PRE_STAGES),
      .SEL_W      (SEL_W)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (cfg_enable),
      .tick    (src_tick),
      .clear   (clr_accept || halt_clr),
      .halted  (halted),
      .sel     (ctl_q[SEL_W-1:0]),
      .ovf_now (ovf_now),
      .req_q   (req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         to_q <= 1'b0;
      else if (!cfg_enable || clr_accept || halt_clr)
         to_q <= 1'b0;
      else if (ovf_now)
         to_q <= 1'b1;
   end

   assign rst_full     = (req == WD_REQ_FULL);
   assign rst_warm     = (req == WD_REQ_WARM);
   assign timeout_flag = to_q;

   assert_warm_needs_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_warm |-> $past(halted));
   assert_kinds_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_full, rst_warm}));
   assert_flag_with_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_full || rst_warm) |-> timeout_flag);
   assert_flag_off_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> !timeout_flag);
endmodule

// File: tb/wdog_paired_clear_tb_top.sv
module wdog_paired_clear_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  MAX_CYCLES = 190000;
   localparam int  K_FULL = 1;
   localparam int  K_WARM = 2;

   typedef struct {
      int    kind;
      int    cyc;
      int    tol;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b1, cfg_src_osc = 1'b1, cfg_dual_clear = 1'b0;
   logic       osc_tick = 1'b0, halted = 1'b0, halt_enter = 1'b0;
   logic       clr_single = 1'b0, clr_one = 1'b0, clr_two = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       rst_full, rst_warm, timeout_flag;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_errors = 0;
   exp_t expq[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_paired_clear dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src_osc(cfg_src_osc),
      .cfg_dual_clear(cfg_dual_clear), .osc_tick(osc_tick), .halted(halted),
      .halt_enter(halt_enter), .clr_single(clr_single), .clr_one(clr_one),
      .clr_two(clr_two), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .rst_full(rst_full), .rst_warm(rst_warm), .timeout_flag(timeout_flag)
   );

   task automatic check_eq(int act, int exp, string tag);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a request pulse is seen
   always @(negedge clk) begin
      if (rst_n && (rst_full || rst_warm)) begin
         int kind;
         kind = (rst_full ? K_FULL : 0) + (rst_warm ? K_WARM : 0);
         n_checks++;
         if (expq.size() == 0) begin
            n_errors++;
            $display("FAIL unexpected request actual kind=%0d cyc=%0d expected none", kind, cyc);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (kind != e.kind || cyc < e.cyc - e.tol || cyc > e.cyc + e.tol) begin
               n_errors++;
               $display("FAIL %s actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                        e.tag, kind, cyc, e.kind, e.cyc);
            end
         end
      end
   end

   task automatic expect_at(int kind, int at, int tol, string tag);
      exp_t e;
      e.kind = kind; e.cyc = at; e.tol = tol; e.tag = tag;
      expq.push_back(e);
   endtask

   // driver: n consecutive oscillator ticks; optional expiry on the last one
   task automatic ticks(int n, int kind, string tag);
      if (kind != 0) expect_at(kind, cyc + n, 0, tag);
      osc_tick = 1'b1;
      repeat (n) @(negedge clk);
      osc_tick = 1'b0;
   endtask

   task automatic strobe(ref logic s);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
   endtask

   task automatic write_ctl(logic [7:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic do_reset(logic en, logic src, logic dual, logic hlt);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_enable = en; cfg_src_osc = src; cfg_dual_clear = dual; halted = hlt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain(string tag);
      repeat (3) @(negedge clk);
      check_eq(expq.size(), 0, tag);
      expq.delete();
   endtask

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset(1'b1, 1'b1, 1'b0, 1'b0);
      check_eq(rst_full, 0, "R1 rst_full");
      check_eq(rst_warm, 0, "R1 rst_warm");
      check_eq(timeout_flag, 0, "R1 timeout_flag");
      check_eq(ctl_rdata, 8'h00, "R1 ctl_rdata");

      // R2 base period, R12 back-to-back restart, R10 flag
      ticks(256, K_FULL, "R2 base period");
      check_eq(timeout_flag, 1, "R10 flag set");
      ticks(256, K_FULL, "R12 restart from zero");
      strobe(clr_single);
      check_eq(timeout_flag, 0, "R10 flag cleared by clear");
      drain("R2 queue");

      // R6 single clear
      ticks(200, 0, "");
      strobe(clr_single);
      ticks(256, K_FULL, "R6 clear restarts");
      ticks(100, 0, "");
      strobe(clr_one);
      strobe(clr_two);
      ticks(156, K_FULL, "R6 paired strobes ignored");
      ticks(255, 0, "");
      clr_single = 1'b1; osc_tick = 1'b1;
      @(negedge clk);
      clr_single = 1'b0; osc_tick = 1'b0;
      ticks(256, K_FULL, "R6 clear beats expiry");
      drain("R6 queue");

      // R4 flag bits, R3 select
      write_ctl(8'hA8);
      check_eq(ctl_rdata, 8'hA8, "R4 readback");
      ticks(256, K_FULL, "R4 flags no effect");
      write_ctl(8'hF9);
      check_eq(ctl_rdata, 8'hF9, "R4 readback sel1");
      ticks(512, K_FULL, "R3 sel 1");
      write_ctl(8'h03);
      ticks(2048, K_FULL, "R3 sel 3");
      write_ctl(8'h07);
      ticks(32768, K_FULL, "R3 sel 7");
      write_ctl(8'h00);
      drain("R3 queue");

      // R8 halt entry clears, R10 flag cleared by halt entry
      ticks(200, 0, "");
      strobe(halt_enter);
      check_eq(timeout_flag, 0, "R10 flag cleared by halt");
      ticks(256, K_FULL, "R8 halt entry restart");
      drain("R8 queue");

      // R9 warm reset while halted
      halted = 1'b1;
      strobe(halt_enter);
      ticks(256, K_WARM, "R9 warm in halt");
      halted = 1'b0;
      drain("R9 queue");

      // R7 paired clear
      do_reset(1'b1, 1'b1, 1'b1, 1'b0);
      ticks(100, 0, "");
      strobe(clr_one);
      ticks(156, K_FULL, "R7 one alone no clear");
      ticks(100, 0, "");
      strobe(clr_two);
      ticks(10, 0, "");
      strobe(clr_one);
      check_eq(timeout_flag, 0, "R10 flag cleared by pair");
      ticks(256, K_FULL, "R7 two then one clears");
      ticks(100, 0, "");
      strobe(clr_single);
      ticks(156, K_FULL, "R7 single ignored");
      ticks(50, 0, "");
      clr_one = 1'b1; clr_two = 1'b1;
      @(negedge clk);
      clr_one = 1'b0; clr_two = 1'b0;
      ticks(256, K_FULL, "R7 same cycle pair");
      ticks(50, 0, "");
      strobe(clr_one);
      strobe(halt_enter);
      ticks(20, 0, "");
      strobe(clr_two);
      ticks(236, K_FULL, "R7 record dropped by halt");
      drain("R7 queue");

      // R5 disabled
      do_reset(1'b0, 1'b1, 1'b0, 1'b0);
      ticks(600, 0, "");
      strobe(clr_single);
      ticks(300, 0, "");
      check_eq(timeout_flag, 0, "R5 flag stays low");
      drain("R5 no requests");

      // R11 instruction clock source
      do_reset(1'b1, 1'b0, 1'b0, 1'b0);
      expect_at(K_FULL, cyc + 1024, 2, "R11 instr period");
      repeat (1100) @(negedge clk);
      drain("R11 queue");
      do_reset(1'b1, 1'b0, 1'b0, 1'b1);
      repeat (1500) @(negedge clk);
      check_eq(rst_full, 0, "R11 halted no count");
      halted = 1'b0;
      expect_at(K_FULL, cyc + 1024, 2, "R11 resume after halt");
      repeat (1100) @(negedge clk);
      drain("R11 resume queue");

      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule